// File: doc/BRIEF.md
# Half-Warp Access Coalescer

This block takes one memory request from a group of sixteen threads, one byte address per thread plus a mask of which threads take part, and decides whether the accesses can be served by a single wide transfer. The group can be served that way when two things hold. First, every participating thread touches the element whose index equals its own position in the group. Second, the block of sixteen elements starts on a boundary equal to its own size. In that case the block emits one merged transaction that carries the block's base address and its byte size. Otherwise it falls back to one element-sized transaction per participating thread, issued in thread order.

The element width is chosen per request: 4, 8 or 16 bytes, which gives merged block sizes of 64, 128 or 256 bytes. Threads left out of the mask are ignored completely, and a request with an empty mask produces nothing. Requests arrive on a valid/ready input channel. Transactions leave on a valid/ready output channel, so a downstream memory port can stall the stream at any point.

The controller is a three-state machine. IDLE accepts a request and, according to the check result, moves to MERGE (rule satisfied), SPLIT (rule broken) or stays in IDLE (empty mask). MERGE presents the single wide transaction and returns to IDLE on its handshake. SPLIT presents the lowest pending thread's transaction, retires it on each handshake, and returns to IDLE when the final one is taken.

Top module: `coal_top`

## Requirements
- R1: While reset is held and right after it, `txn_valid` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only while no transaction is pending. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1.
- R3: `req_esize` encodes the element width: 0 = 4 bytes, 1 = 8 bytes, 2 = 16 bytes, and 3 is treated as 16 bytes.
- R4: Let B be the address of the lowest active thread minus that thread's index times E, where E is the element width. If B is a multiple of 16·E and every active thread k addresses B + k·E, exactly one transaction is issued with `txn_addr` = B, `txn_bytes` = 16·E, `txn_merged` = 1 and `txn_lane` = 0.
- R5: The address of an inactive thread has no effect on the merge decision or on any transaction.
- R6: A merged transaction is valid in the cycle right after the request is taken.
- R7: If the R4 rule fails, one transaction is issued per active thread in ascending thread index. Each carries that thread's address, `txn_bytes` = E, `txn_merged` = 0 and `txn_lane` = the thread index. The first is valid in the cycle after acceptance.
- R8: A request whose mask is all zero issues no transaction, and `req_ready` stays 1.
- R9: While `txn_valid` is 1 and `txn_ready` is 0, the presented transaction holds its values unchanged.
- R10: With `txn_ready` held at 1, split transactions leave one per cycle, and `req_ready` returns to 1 in the cycle after the last handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | NUM_LANES*ADDR_W | Byte address per thread; thread k occupies bits [k*ADDR_W +: ADDR_W] |
| req_active | input | NUM_LANES | Bit k set means thread k takes part |
| req_esize | input | 2 | Element width code (see R3) |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_addr | output | ADDR_W | Transaction start byte address |
| txn_bytes | output | $clog2(NUM_LANES*16)+1 | Transaction length in bytes |
| txn_merged | output | 1 | 1 for a merged block, 0 for a single element |
| txn_lane | output | $clog2(NUM_LANES) | Thread index of a single-element transaction, 0 when merged |

## Verification
The assertions assume that the downstream side obeys the usual handshake: it may stall freely, but it judges a transaction only while `txn_valid` is high. They also assume that request fields are sampled only on the accepting edge, so address and mask values are free to change at other times. The stimulus drives every input at the falling edge and holds it through the next rising edge. It changes `req_addr` contents freely between requests and stalls `txn_ready` at random during the stress phase, which stays inside those assumptions. Address vectors include aligned blocks, blocks offset by a small amount, swapped thread orders and sparse masks with junk in the inactive threads. Together these drive both the R4 merge path and the R7 fallback path under stalls.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MERGE = 2'd1,
        ST_SPLIT = 2'd2
    } coal_state_e;

    // log2 of the element width in bytes; code 3 folds onto code 2
    function automatic logic [2:0] esize_shift(input logic [1:0] code);
        logic [2:0] sh;
        if (code >= 2'd2) sh = 3'd4;
        else              sh = {1'b0, code} + 3'd2;
        return sh;
    endfunction

endpackage

// File: rtl/coal_check.sv
module coal_check #(
    parameter int NUM_LANES = 16,
    parameter int ADDR_W    = 32,
    localparam int LANE_W   = $clog2(NUM_LANES)
) (
    input  logic [NUM_LANES*ADDR_W-1:0] addr_flat,
    input  logic [NUM_LANES-1:0]        active,
    input  logic [2:0]                  esh,
    output logic                        merge_ok,
    output logic [ADDR_W-1:0]           base
);
    logic [ADDR_W-1:0]    lanes [NUM_LANES];
    logic [NUM_LANES-1:0] lane_ok;
    logic [LANE_W-1:0]    first;
    logic [ADDR_W-1:0]    region_mask;

    // lowest active thread anchors the candidate block
    always_comb begin
        first = '0;
        for (int k = NUM_LANES - 1; k >= 0; k--) begin
            if (active[k]) first = LANE_W'(k);
        end
    end

    assign base        = lanes[first] - (ADDR_W'(first) << esh);
    assign region_mask = (ADDR_W'(NUM_LANES) << esh) - ADDR_W'(1);

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        assign lanes[k]   = addr_flat[k*ADDR_W +: ADDR_W];
        assign lane_ok[k] = !active[k] || (lanes[k] == base + (ADDR_W'(k) << esh));
    end

    assign merge_ok = (&lane_ok) && ((base & region_mask) == '0) && (|active);

endmodule

// File: rtl/coal_pick.sv
module coal_pick #(
    parameter int NUM_LANES = 16,
    localparam int LANE_W   = $clog2(NUM_LANES)
) (
    input  logic [NUM_LANES-1:0] pend,
    output logic [LANE_W-1:0]    idx
);
    always_comb begin
        idx = '0;
        for (int k = NUM_LANES - 1; k >= 0; k--) begin
            if (pend[k]) idx = LANE_W'(k);
        end
    end
endmodule

// File: rtl/coal_top.sv
module coal_top
    import coal_pkg::*;
#(
    parameter int NUM_LANES = 16,
    parameter int ADDR_W    = 32,
    localparam int LANE_W   = $clog2(NUM_LANES),
    localparam int BYTES_W  = $clog2(NUM_LANES*16) + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [NUM_LANES*ADDR_W-1:0] req_addr,
    input  logic [NUM_LANES-1:0]        req_active,
    input  logic [1:0]                  req_esize,
    output logic                        txn_valid,
    input  logic                        txn_ready,
    output logic [ADDR_W-1:0]           txn_addr,
    output logic [BYTES_W-1:0]          txn_bytes,
    output logic                        txn_merged,
    output logic [LANE_W-1:0]           txn_lane
);
    coal_state_e          state_q;
    logic [ADDR_W-1:0]    lanes_q [NUM_LANES];
    logic [NUM_LANES-1:0] pend_q;
    logic [ADDR_W-1:0]    base_q;
    logic [2:0]           esh_q;

    logic [2:0]           esh_in;
    logic                 chk_ok;
    logic [ADDR_W-1:0]    chk_base;
    logic [LANE_W-1:0]    pick_idx;
    logic                 accept;
    logic                 last_one;

    assign esh_in    = esize_shift(req_esize);
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    coal_check #(.NUM_LANES(NUM_LANES), .ADDR_W(ADDR_W)) u_check (
        .addr_flat (req_addr),
        .active    (req_active),
        .esh       (esh_in),
        .merge_ok  (chk_ok),
        .base      (chk_base)
    );

    coal_pick #(.NUM_LANES(NUM_LANES)) u_pick (
        .pend (pend_q),
        .idx  (pick_idx)
    );

    assign last_one = (pend_q & ~(NUM_LANES'(1) << pick_idx)) == '0;

    // state register and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            base_q  <= '0;
            esh_q   <= 3'd2;
            for (int k = 0; k < NUM_LANES; k++) lanes_q[k] <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        for (int k = 0; k < NUM_LANES; k++)
                            lanes_q[k] <= req_addr[k*ADDR_W +: ADDR_W];
                        pend_q <= req_active;
                        base_q <= chk_base;
                        esh_q  <= esh_in;
                        if (req_active == '0) state_q <= ST_IDLE;
                        else if (chk_ok)      state_q <= ST_MERGE;
                        else                  state_q <= ST_SPLIT;
                    end
                end
                ST_MERGE: begin
                    if (txn_ready) begin
                        pend_q  <= '0;
                        state_q <= ST_IDLE;
                    end
                end
                ST_SPLIT: begin
                    if (txn_ready) begin
                        pend_q[pick_idx] <= 1'b0;
                        if (last_one) state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs from state
    always_comb begin
        txn_valid  = 1'b0;
        txn_addr   = '0;
        txn_bytes  = '0;
        txn_merged = 1'b0;
        txn_lane   = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_MERGE: begin
                txn_valid  = 1'b1;
                txn_addr   = base_q;
                txn_bytes  = BYTES_W'(NUM_LANES) << esh_q;
                txn_merged = 1'b1;
            end
            ST_SPLIT: begin
                txn_valid  = 1'b1;
                txn_addr   = lanes_q[pick_idx];
                txn_bytes  = BYTES_W'(1) << esh_q;
                txn_lane   = pick_idx;
            end
            default: ;
        endcase
    end

    // R9: a stalled transaction does not change
    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_addr)
            && $stable(txn_bytes) && $stable(txn_lane) && $stable(txn_merged));

    // R8: empty mask leaves the block idle
    a_r8_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (req_active == '0) |=> !txn_valid && req_ready);

    // R6: qualifying request shows its merged transfer one cycle later
    a_r6_merge_next: assert property (@(posedge clk) disable iff (!rst_n)
        accept && chk_ok |=> txn_valid && txn_merged);

    // R4: merged block is a power of two, at least 16 words of 4 bytes, and aligned to itself
    a_r4_merge_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && txn_merged |-> ($countones(txn_bytes) == 1)
            && (txn_bytes >= BYTES_W'(NUM_LANES*4))
            && ((txn_addr & (ADDR_W'(txn_bytes) - ADDR_W'(1))) == '0));

    // R7: split transactions come out in rising thread order
    a_r7_split_order: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_merged && txn_ready |=>
            !(txn_valid && !txn_merged) || (txn_lane > $past(txn_lane)));

    // R3: a single-element transfer is 4, 8 or 16 bytes
    a_r3_elem_size: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_merged |-> (txn_bytes == BYTES_W'(4))
            || (txn_bytes == BYTES_W'(8)) || (txn_bytes == BYTES_W'(16)));

endmodule

// File: tb/coal_top_tb.sv
`timescale 1ns/1ps
module coal_top_tb_top;
    localparam int NT = 16;
    localparam int AW = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic              req_ready;
    logic [NT*AW-1:0]  req_addr;
    logic [NT-1:0]     req_active;
    logic [1:0]        req_esize;
    logic              txn_valid;
    logic              txn_ready;
    logic [AW-1:0]     txn_addr;
    logic [8:0]        txn_bytes;
    logic              txn_merged;
    logic [3:0]        txn_lane;

    always #4 clk = ~clk;

    coal_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_active(req_active), .req_esize(req_esize),
        .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_addr(txn_addr), .txn_bytes(txn_bytes),
        .txn_merged(txn_merged), .txn_lane(txn_lane)
    );

    typedef struct {
        logic [31:0] a;
        int          b;
        bit          m;
        int          l;
    } exp_t;

    exp_t        q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] s_addr [NT];
    logic [NT-1:0] s_mask;
    logic [1:0]  s_esz;
    bit          have_req = 0;
    int          rdy_pct = 100;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // reference: expected transactions for the staged request (R3, R4, R5, R7, R8)
    function automatic void model_push();
        int e;
        int low;
        bit ok;
        logic [31:0] base;
        e = 4 << ((s_esz > 2) ? 2 : int'(s_esz));
        low = -1;
        for (int k = 0; k < NT; k++) if (s_mask[k] && low < 0) low = k;
        if (low < 0) return;
        base = s_addr[low] - 32'(low * e);
        ok = ((base % (16 * e)) == 0);
        for (int k = 0; k < NT; k++)
            if (s_mask[k] && s_addr[k] != base + 32'(k * e)) ok = 0;
        if (ok) q.push_back('{base, 16 * e, 1'b1, 0});
        else
            for (int k = 0; k < NT; k++)
                if (s_mask[k]) q.push_back('{s_addr[k], e, 1'b0, k});
    endfunction

    task automatic step();
        string tg;
        @(negedge clk);
        if (q.size() != 0) begin
            tg = q[0].m ? "R4/R6" : "R7/R10";
            chk(txn_valid == 1'b1, tg, "txn_valid", txn_valid, 1);
            if (txn_valid) begin
                chk(txn_addr == q[0].a, tg, "txn_addr", txn_addr, q[0].a);
                chk(int'(txn_bytes) == q[0].b, "R3", "txn_bytes", txn_bytes, q[0].b);
                chk(txn_merged == q[0].m, tg, "txn_merged", txn_merged, q[0].m);
                chk(int'(txn_lane) == q[0].l, "R7", "txn_lane", txn_lane, q[0].l);
            end
            chk(req_ready == 1'b0, "R2", "req_ready busy", req_ready, 0);
        end else begin
            chk(txn_valid == 1'b0, "R8", "txn_valid idle", txn_valid, 0);
            chk(req_ready == 1'b1, "R10", "req_ready idle", req_ready, 1);
        end
        txn_ready  = ($urandom_range(99) < rdy_pct);
        req_valid  = have_req;
        req_active = s_mask;
        req_esize  = s_esz;
        for (int k = 0; k < NT; k++) req_addr[k*AW +: AW] = s_addr[k];
        if (req_valid && req_ready) begin
            model_push();
            have_req = 0;
        end
        if (txn_valid && txn_ready && q.size() != 0) void'(q.pop_front());
    endtask

    task automatic send();
        have_req = 1;
        while (have_req) step();
        while (q.size() != 0) step();
        step();
    endtask

    task automatic fill_lin(input logic [31:0] base, input int e);
        for (int k = 0; k < NT; k++) s_addr[k] = base + 32'(k * e);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] t;
        rst_n = 0; req_valid = 0; txn_ready = 0; req_active = '0;
        req_esize = 0; req_addr = '0; s_mask = '0; s_esz = 0;
        for (int k = 0; k < NT; k++) s_addr[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(txn_valid == 0, "R1", "txn_valid in reset", txn_valid, 0);
        chk(req_ready == 1, "R1", "req_ready in reset", req_ready, 1);
        rst_n = 1;
        step();

        // R4 R6: aligned full blocks for each element width (R3)
        s_mask = '1; s_esz = 0; fill_lin(32'h1000, 4);  send();
        s_esz = 1;  fill_lin(32'h2080, 8);  send();
        s_esz = 2;  fill_lin(32'h3100, 16); send();
        // R3: code 3 behaves as 16 bytes
        s_esz = 3;  fill_lin(32'h4200, 16); send();
        // R5: sparse mask, junk in inactive threads, thread 0 off
        s_esz = 0; fill_lin(32'h5040, 4);
        s_mask = 16'b1010_0000_1100_0110;
        for (int k = 0; k < NT; k++) if (!s_mask[k]) s_addr[k] = 32'hDEAD_0000 + 32'(k);
        send();
        // R7 R10: misaligned block splits into 16 back to back
        s_mask = '1; s_esz = 0; fill_lin(32'h1010, 4); send();
        // R7: two threads swapped
        fill_lin(32'h6000, 8); s_esz = 1;
        t = s_addr[3]; s_addr[3] = s_addr[4]; s_addr[4] = t; send();
        // R8: empty mask
        s_mask = '0; fill_lin(32'h7000, 4); send();
        // R7: single active thread off its slot
        s_mask = 16'h0100; s_esz = 0; fill_lin(32'h8000, 4); s_addr[8] = 32'h8004; send();

        // R9: random stalls with mixed patterns
        rdy_pct = 55;
        for (int n = 0; n < 400; n++) begin
            int e;
            s_esz = 2'($urandom_range(3));
            e = 4 << ((s_esz > 2) ? 2 : int'(s_esz));
            case ($urandom_range(5))
                0:       s_mask = '0;
                1, 2:    s_mask = '1;
                default: s_mask = NT'($urandom);
            endcase
            fill_lin(($urandom & 32'hFFFF_F000) + 32'(($urandom_range(3)) * 16 * e), e);
            if ($urandom_range(2) == 0) s_addr[$urandom_range(NT-1)] += 32'(e);
            if ($urandom_range(4) == 0) for (int k = 0; k < NT; k++) s_addr[k] += 32'h4;
            for (int k = 0; k < NT; k++) if (!s_mask[k] && $urandom_range(1)) s_addr[k] = $urandom;
            send();
        end
        finish_run();
    end
endmodule